// File: doc/BRIEF.md
# Load-Use and Branch Stall Accounting Unit

This block keeps timing statistics for a simple in-order pipeline. Each issued instruction arrives as one strobed beat that carries its class, up to two source register numbers (each with its own presence flag), a destination register number and a branch outcome. The unit does not stall anything. It only counts the cycles that a pipeline of this shape would lose to load-use hazards and to taken control transfers, and it counts taken and not-taken transfers.

A load marks its destination register. The mark applies only to the next instruction that advances the hazard window. If that instruction reads the marked register through a checked source port, the load-stall counter grows by a fixed penalty of 2 for each such source. A taken control transfer adds its own fixed penalty of 2 to a separate counter. All four counters can be read at the ports at all times.

Top module: `stall_ledger`

## Requirements
- R1: While rst_n is low, all four counters read zero and the hazard mask is cleared. A load issued before reset causes no stall for an instruction issued after reset.
- R2: For classes exec (code 0), compare (code 1) and multiply-accumulate (code 2), both source ports are checked. Each present source whose register is marked by the previous mask-advancing instruction adds 2 to load_stall_cnt, so two matching sources add 4.
- R3: A source whose presence flag is low is never checked and adds nothing, whatever its register number is.
- R4: A control-transfer instruction (code 3) checks only source A. A match on source B adds nothing.
- R5: A load (code 4) marks its destination register for the next instruction of codes 0 to 4. It replaces any earlier mark, and the load itself checks no sources. Any non-load instruction of codes 0 to 4 clears the mark for the instruction after it.
- R6: A taken control transfer adds 2 to xfer_stall_cnt and 1 to taken_cnt.
- R7: A not-taken control transfer adds 1 to untaken_cnt and leaves xfer_stall_cnt unchanged.
- R8: A store (code 5) and the unused codes 6 and 7 change no counter and leave the hazard mask as it was.
- R9: Cycles with insn_valid low change no counter and keep the hazard mask, so a load still penalizes the next instruction after idle cycles.
- R10: Inputs are sampled on the rising clock edge while insn_valid is high. The counter updates are visible immediately after that edge, and all counters are 32 bits wide and wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_valid | input | 1 | Instruction strobe |
| insn_class | input | 3 | Instruction class code |
| src_a | input | 4 | Source A register number |
| src_a_vld | input | 1 | Source A present |
| src_b | input | 4 | Source B register number |
| src_b_vld | input | 1 | Source B present |
| dst | input | 4 | Destination register number |
| taken | input | 1 | Control transfer taken |
| load_stall_cnt | output | 32 | Accumulated load-use stall cycles |
| xfer_stall_cnt | output | 32 | Accumulated control-transfer stall cycles |
| taken_cnt | output | 32 | Taken control transfers |
| untaken_cnt | output | 32 | Not-taken control transfers |

## Verification
The hazard mask cannot be seen directly. A wrong mask therefore shows up one instruction later as a missing or extra step of 2 or 4 in load_stall_cnt, when a dependent instruction issues. For this reason every load in the stimulus is followed by readers that do and do not match its destination, both with and without idle cycles or stores in between. Counter errors appear on the edge right after the strobed instruction, so every counter is compared after every cycle.

// File: rtl/stall_ledger_pkg.sv
package stall_ledger_pkg;

    typedef enum logic [2:0] {
        CLS_EXEC  = 3'd0,
        CLS_CMP   = 3'd1,
        CLS_MAC   = 3'd2,
        CLS_XFER  = 3'd3,
        CLS_LOAD  = 3'd4,
        CLS_STORE = 3'd5,
        CLS_RSV6  = 3'd6,
        CLS_RSV7  = 3'd7
    } insn_cls_e;

    // Which source ports a class examines: bit 0 = A, bit 1 = B
    function automatic logic [1:0] srcs_checked(insn_cls_e c);
        case (c)
            CLS_EXEC, CLS_CMP, CLS_MAC: srcs_checked = 2'b11;
            CLS_XFER:                   srcs_checked = 2'b01;
            default:                    srcs_checked = 2'b00;
        endcase
    endfunction

    // Classes that move the hazard window forward
    function automatic logic advances_window(insn_cls_e c);
        advances_window = (c == CLS_EXEC) || (c == CLS_CMP) || (c == CLS_MAC) ||
                          (c == CLS_XFER) || (c == CLS_LOAD);
    endfunction

endpackage

// File: rtl/ledger_hazard_mask.sv
module ledger_hazard_mask
    import stall_ledger_pkg::*;
#(
    parameter int NUM_REGS = 16,
    parameter int REG_W    = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             insn_valid,
    input  insn_cls_e        cls,
    input  logic [REG_W-1:0] src_a,
    input  logic             src_a_vld,
    input  logic [REG_W-1:0] src_b,
    input  logic             src_b_vld,
    input  logic [REG_W-1:0] dst,
    output logic [1:0]       hit_cnt
);

    localparam int NUM_SRC = 2;

    typedef struct packed {
        logic [NUM_REGS-1:0] marked;
    } mask_st_t;

    mask_st_t st_d, st_q;

    logic [REG_W-1:0]   src_idx [NUM_SRC];
    logic [NUM_SRC-1:0] src_vld;
    logic [NUM_SRC-1:0] src_chk;
    logic [NUM_SRC-1:0] src_hit;

    assign src_idx[0] = src_a;
    assign src_idx[1] = src_b;
    assign src_vld    = {src_b_vld, src_a_vld};
    assign src_chk    = srcs_checked(cls);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        assign src_hit[i] = insn_valid & src_chk[i] & src_vld[i] & st_q.marked[src_idx[i]];
    end

    assign hit_cnt = {1'b0, src_hit[0]} + {1'b0, src_hit[1]};

    always_comb begin
        st_d = st_q;
        if (insn_valid && advances_window(cls)) begin
            st_d.marked = '0;
            if (cls == CLS_LOAD) begin
                st_d.marked[dst] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R4
    xfer_single_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && cls == CLS_XFER) |-> (hit_cnt <= 2'd1));

    // R5
    load_no_check_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && cls == CLS_LOAD) |-> (hit_cnt == 2'd0));

    // R5
    single_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(st_q.marked));

endmodule

// File: rtl/ledger_counters.sv
module ledger_counters
    import stall_ledger_pkg::*;
#(
    parameter int CNT_W        = 32,
    parameter int LOAD_PENALTY = 2,
    parameter int XFER_PENALTY = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             insn_valid,
    input  insn_cls_e        cls,
    input  logic             taken,
    input  logic [1:0]       hit_cnt,
    output logic [CNT_W-1:0] load_stall_cnt,
    output logic [CNT_W-1:0] xfer_stall_cnt,
    output logic [CNT_W-1:0] taken_cnt,
    output logic [CNT_W-1:0] untaken_cnt
);

    localparam logic [CNT_W-1:0] LD_STEP = CNT_W'(LOAD_PENALTY);
    localparam logic [CNT_W-1:0] XF_STEP = CNT_W'(XFER_PENALTY);

    typedef struct packed {
        logic [CNT_W-1:0] ld;
        logic [CNT_W-1:0] xf;
        logic [CNT_W-1:0] tk;
        logic [CNT_W-1:0] nt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (insn_valid) begin
            st_d.ld = st_q.ld + CNT_W'(hit_cnt) * LD_STEP;
            if (cls == CLS_XFER) begin
                if (taken) begin
                    st_d.xf = st_q.xf + XF_STEP;
                    st_d.tk = st_q.tk + 1'b1;
                end else begin
                    st_d.nt = st_q.nt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign load_stall_cnt = st_q.ld;
    assign xfer_stall_cnt = st_q.xf;
    assign taken_cnt      = st_q.tk;
    assign untaken_cnt    = st_q.nt;

    // R2
    stall_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        insn_valid |=> ((load_stall_cnt - $past(load_stall_cnt)) == '0 ||
                        (load_stall_cnt - $past(load_stall_cnt)) == LD_STEP ||
                        (load_stall_cnt - $past(load_stall_cnt)) == (LD_STEP + LD_STEP)));

    // R6
    taken_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && cls == CLS_XFER && taken) |=>
            (xfer_stall_cnt == $past(xfer_stall_cnt) + XF_STEP) &&
            (taken_cnt == $past(taken_cnt) + 1'b1) && $stable(untaken_cnt));

    // R7
    untaken_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && cls == CLS_XFER && !taken) |=>
            (untaken_cnt == $past(untaken_cnt) + 1'b1) &&
            $stable(xfer_stall_cnt) && $stable(taken_cnt));

    // R8
    store_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && (cls == CLS_STORE || cls == CLS_RSV6 || cls == CLS_RSV7)) |=>
            $stable(load_stall_cnt) && $stable(xfer_stall_cnt) &&
            $stable(taken_cnt) && $stable(untaken_cnt));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !insn_valid |=> $stable(load_stall_cnt) && $stable(xfer_stall_cnt) &&
                        $stable(taken_cnt) && $stable(untaken_cnt));

endmodule

// File: rtl/stall_ledger.sv
module stall_ledger
    import stall_ledger_pkg::*;
#(
    parameter int NUM_REGS     = 16,
    parameter int CNT_W        = 32,
    parameter int LOAD_PENALTY = 2,
    parameter int XFER_PENALTY = 2,
    localparam int REG_W       = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             insn_valid,
    input  logic [2:0]       insn_class,
    input  logic [REG_W-1:0] src_a,
    input  logic             src_a_vld,
    input  logic [REG_W-1:0] src_b,
    input  logic             src_b_vld,
    input  logic [REG_W-1:0] dst,
    input  logic             taken,
    output logic [CNT_W-1:0] load_stall_cnt,
    output logic [CNT_W-1:0] xfer_stall_cnt,
    output logic [CNT_W-1:0] taken_cnt,
    output logic [CNT_W-1:0] untaken_cnt
);

    insn_cls_e  cls;
    logic [1:0] hit_cnt;

    assign cls = insn_cls_e'(insn_class);

    ledger_hazard_mask #(
        .NUM_REGS (NUM_REGS),
        .REG_W    (REG_W)
    ) u_mask (
        .clk        (clk),
        .rst_n      (rst_n),
        .insn_valid (insn_valid),
        .cls        (cls),
        .src_a      (src_a),
        .src_a_vld  (src_a_vld),
        .src_b      (src_b),
        .src_b_vld  (src_b_vld),
        .dst        (dst),
        .hit_cnt    (hit_cnt)
    );

    ledger_counters #(
        .CNT_W        (CNT_W),
        .LOAD_PENALTY (LOAD_PENALTY),
        .XFER_PENALTY (XFER_PENALTY)
    ) u_cnt (
        .clk            (clk),
        .rst_n          (rst_n),
        .insn_valid     (insn_valid),
        .cls            (cls),
        .taken          (taken),
        .hit_cnt        (hit_cnt),
        .load_stall_cnt (load_stall_cnt),
        .xfer_stall_cnt (xfer_stall_cnt),
        .taken_cnt      (taken_cnt),
        .untaken_cnt    (untaken_cnt)
    );

    // R3
    absent_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && !src_a_vld && !src_b_vld) |=> $stable(load_stall_cnt));

endmodule

// File: tb/stall_ledger_tb.sv
`timescale 1ns/1ps
module stall_ledger_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_valid = 1'b0;
    logic [2:0]  insn_class = '0;
    logic [3:0]  src_a = '0, src_b = '0, dst = '0;
    logic        src_a_vld = 1'b0, src_b_vld = 1'b0, taken = 1'b0;
    logic [31:0] load_stall_cnt, xfer_stall_cnt, taken_cnt, untaken_cnt;

    int nvec = 0;
    int nbad = 0;
    bit done = 1'b0;

    // bench-side model state
    logic [15:0] m_mark = '0;
    logic [31:0] m_ld = '0, m_xf = '0, m_tk = '0, m_nt = '0;

    always #2.5 clk = ~clk;

    stall_ledger u_dut (
        .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_class(insn_class),
        .src_a(src_a), .src_a_vld(src_a_vld), .src_b(src_b), .src_b_vld(src_b_vld),
        .dst(dst), .taken(taken),
        .load_stall_cnt(load_stall_cnt), .xfer_stall_cnt(xfer_stall_cnt),
        .taken_cnt(taken_cnt), .untaken_cnt(untaken_cnt)
    );

    function automatic int exp_hits(logic [2:0] c, logic [3:0] a, logic av,
                                    logic [3:0] b, logic bv, logic [15:0] mk);
        int h = 0;
        if (c <= 3'd3 && av && mk[a]) h++;
        if (c <= 3'd2 && bv && mk[b]) h++;
        return h;
    endfunction

    function automatic logic [15:0] next_mark(logic [2:0] c, logic [3:0] d, logic [15:0] mk);
        if (c <= 3'd3) return '0;
        if (c == 3'd4) return 16'(1) << d;
        return mk;
    endfunction

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        check(tag, "load_stall_cnt", load_stall_cnt, m_ld);
        check(tag, "xfer_stall_cnt", xfer_stall_cnt, m_xf);
        check(tag, "taken_cnt", taken_cnt, m_tk);
        check(tag, "untaken_cnt", untaken_cnt, m_nt);
    endtask

    // called just after a rising edge; drives one cycle and checks after the next edge
    task automatic step(string tag, logic v, logic [2:0] c, logic [3:0] a, logic av,
                        logic [3:0] b, logic bv, logic [3:0] d, logic t);
        insn_valid = v; insn_class = c; src_a = a; src_a_vld = av;
        src_b = b; src_b_vld = bv; dst = d; taken = t;
        if (v) begin
            m_ld = m_ld + 32'(2 * exp_hits(c, a, av, b, bv, m_mark));
            if (c == 3'd3) begin
                if (t) begin m_xf = m_xf + 2; m_tk = m_tk + 1; end
                else   m_nt = m_nt + 1;
            end
            m_mark = next_mark(c, d, m_mark);
        end
        @(posedge clk);
        #1;
        check_all(tag);
    endtask

    task automatic idle(string tag);
        step(tag, 1'b0, 3'd0, 4'd0, 1'b0, 4'd0, 1'b0, 4'd0, 1'b0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        insn_valid = 1'b0;
        m_mark = '0; m_ld = '0; m_xf = '0; m_tk = '0; m_nt = '0;
        repeat (2) @(posedge clk);
        #1;
        check_all("R1");
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nbad++;
            nvec++;
            $display("FAIL R10 watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        @(posedge clk); #1;
        do_reset();

        // R2: load then exec reading it on both ports -> +4
        step("R5", 1, 3'd4, 4'd1, 1, 4'd2, 1, 4'd7, 0);
        step("R2", 1, 3'd0, 4'd7, 1, 4'd7, 1, 4'd0, 0);
        // R5: penalty only for the immediately following instruction
        step("R5", 1, 3'd1, 4'd7, 1, 4'd7, 1, 4'd0, 0);
        // R2: mac with one matching source -> +2
        step("R5", 1, 3'd4, 4'd0, 0, 4'd0, 0, 4'd3, 0);
        step("R2", 1, 3'd2, 4'd9, 1, 4'd3, 1, 4'd0, 0);
        // R3: absent sources are ignored
        step("R5", 1, 3'd4, 4'd0, 0, 4'd0, 0, 4'd5, 0);
        step("R3", 1, 3'd0, 4'd5, 0, 4'd5, 0, 4'd0, 0);
        // R4: xfer only checks source A
        step("R5", 1, 3'd4, 4'd0, 0, 4'd0, 0, 4'd6, 0);
        step("R4", 1, 3'd3, 4'd1, 1, 4'd6, 1, 4'd0, 1);
        step("R5", 1, 3'd4, 4'd0, 0, 4'd0, 0, 4'd6, 0);
        step("R4", 1, 3'd3, 4'd6, 1, 4'd6, 1, 4'd0, 0);
        // R6 / R7
        step("R6", 1, 3'd3, 4'd0, 0, 4'd0, 0, 4'd0, 1);
        step("R7", 1, 3'd3, 4'd0, 0, 4'd0, 0, 4'd0, 0);
        // R9: mark survives idle cycles
        step("R5", 1, 3'd4, 4'd0, 0, 4'd0, 0, 4'd8, 0);
        idle("R9");
        idle("R9");
        step("R9", 1, 3'd0, 4'd8, 1, 4'd0, 0, 4'd0, 0);
        // R8: store and unused codes leave mark and counters
        step("R5", 1, 3'd4, 4'd0, 0, 4'd0, 0, 4'd11, 0);
        step("R8", 1, 3'd5, 4'd11, 1, 4'd11, 1, 4'd2, 1);
        step("R8", 1, 3'd6, 4'd11, 1, 4'd11, 1, 4'd2, 1);
        step("R8", 1, 3'd7, 4'd11, 1, 4'd11, 1, 4'd2, 1);
        step("R8", 1, 3'd1, 4'd11, 1, 4'd0, 0, 4'd0, 0);
        // R5: back-to-back loads; second replaces the mark and checks nothing
        step("R5", 1, 3'd4, 4'd0, 0, 4'd0, 0, 4'd12, 0);
        step("R5", 1, 3'd4, 4'd12, 1, 4'd12, 1, 4'd13, 0);
        step("R5", 1, 3'd0, 4'd12, 1, 4'd13, 1, 4'd0, 0);
        // R1: a pre-reset load must not penalize after reset
        step("R1", 1, 3'd4, 4'd0, 0, 4'd0, 0, 4'd4, 0);
        do_reset();
        step("R1", 1, 3'd0, 4'd4, 1, 4'd4, 1, 4'd0, 0);

        // R10: random mix, registers drawn from a small set to force hits
        for (int i = 0; i < 4000; i++) begin
            logic v;
            logic [2:0] c;
            v = ($urandom % 5) != 0;
            c = 3'($urandom % 8);
            if (($urandom % 3) == 0) c = 3'd4;
            step("R10", v, c, 4'($urandom % 4), 1'($urandom), 4'($urandom % 4),
                 1'($urandom), 4'($urandom % 4), 1'($urandom));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule